// File: doc/BRIEF.md
# PHY Training Stage Sequencer with Status Mailbox

This block steps a memory PHY through its bring-up phases and runs the training stages that a 16-bit control word selects. The bring-up runs from power and clock start through configuration, instruction load, frequency set and parameter load. It then validates the control word and runs each enabled stage through a start/done handshake with an external stage engine, from the lowest bit to the highest. Stages whose bit is clear are skipped. Training ends with results read-back, init-engine load, DFI initialization and mission mode.

Progress is reported through a single-entry mailbox that a host polls. Each message is one byte. The block posts a streaming-mode entry code first, then a fixed completion code as each stage finishes, and finally an overall pass or fail code. A message stays valid until the host acknowledges it. A new message waits while the mailbox is full, and the sequencer stalls until the host drains it.

Top module: `train_seq_top`

## Requirements
- R1: After synchronous reset, busy, failed, selfref, stg_start and mbx_valid are 0 and phase is 0.
- R2: Phase codes are power 0, clocks/reset 1, configuration 2, instruction load 3, frequency set 4, parameter load 5, execute 6, results 7, init engine 8, DFI init 9, mission 10. While the sequencer runs, phase only ever moves up by one.
- R3: A control word is rejected if bit 0 is clear or if any of bits 5, 8, 11 or 15 is set. A rejected word posts only 0xFF, starts no stage, sets failed, and leaves phase at 6.
- R4: An accepted control word posts 0x08 (streaming mode entry) before any stage starts.
- R5: Enabled stages run in ascending bit order, and a stage whose bit is clear is skipped. Each stage gets a one-cycle stg_start pulse with stg_sel equal to its bit index. The next stage starts only after stg_done.
- R6: A stage that passes posts its completion code. The codes by bit are: 1 gives 0x01, 2 gives 0x02, 3 gives 0x03, 4 gives 0x04, 6 gives 0x06, 7 gives 0x0A, 9 gives 0x09, 10 gives 0x0E, 12 gives 0x0D and 14 gives 0x14. Bits 0 and 13 post nothing.
- R7: If every enabled stage passes, the block posts 0x07, sets selfref, moves phase through 7, 8 and 9 to 10, and then drops busy.
- R8: A stg_done with stg_fail high posts 0xFF, starts no further stage, sets failed, and leaves phase at 6.
- R9: mbx_valid and mbx_code hold until mbx_ack. mbx_valid falls in the cycle after the acknowledge. A new message is written only into an empty mailbox.
- R10: A start pulse in idle, mission or failed state begins a new run at phase 0 with selfref and failed cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (accepted when not busy) |
| ctrl_word | input | 16 | Stage-select control word, captured at start |
| stg_start | output | 1 | One-cycle request to the stage engine |
| stg_sel | output | 4 | Bit index of the stage being run |
| stg_done | input | 1 | Stage engine completion strobe |
| stg_fail | input | 1 | Qualifies stg_done as a failure |
| mbx_valid | output | 1 | Mailbox holds an unread message |
| mbx_code | output | 8 | Message byte |
| mbx_ack | input | 1 | Host consumed the message |
| phase | output | 4 | Current bring-up phase code |
| busy | output | 1 | Run in progress |
| failed | output | 1 | Run ended in failure |
| selfref | output | 1 | Training finished and memory left in self-refresh |

## Verification
Phase reads 0 at the sample point right after the edge that takes start, and then rises by one per cycle. mbx_valid drops at the first sample after the edge that takes an acknowledge. stg_start lasts exactly one sample. A stage engine that answers with zero extra latency can raise stg_done at the sample after the pulse, because the sequencer first looks for done in the cycle after the launch. The bench models both the stage engine and the host with delays that change from run to run. At each falling edge it checks, against lists built from the control word and the chosen failing stage, which stage starts, which message is posted, that stg_start is a single pulse and that mbx_valid has cleared. At the end of each run it checks the final phase and flags.

// File: rtl/train_seq_pkg.sv
package train_seq_pkg;

    localparam int CW_BITS = 16;
    localparam int SEL_W   = $clog2(CW_BITS);
    localparam int MSG_W   = 8;

    localparam logic [CW_BITS-1:0] RSVD_MASK = 16'h8920;
    localparam logic [MSG_W-1:0]   MSG_STREAM = 8'h08;
    localparam logic [MSG_W-1:0]   MSG_PASS   = 8'h07;
    localparam logic [MSG_W-1:0]   MSG_FAIL   = 8'hFF;

    typedef enum logic [3:0] {
        PH_POWER   = 4'd0,
        PH_CLKRST  = 4'd1,
        PH_CONFIG  = 4'd2,
        PH_IMEM    = 4'd3,
        PH_FREQ    = 4'd4,
        PH_PARAM   = 4'd5,
        PH_EXEC    = 4'd6,
        PH_RESULTS = 4'd7,
        PH_PIE     = 4'd8,
        PH_DFI     = 4'd9,
        PH_MISSION = 4'd10
    } phase_t;

    typedef enum logic [3:0] {
        S_IDLE, S_BRING, S_CHECK, S_SEEK, S_LAUNCH,
        S_WAIT, S_POST, S_TAIL, S_MISSION, S_HALT
    } seq_state_t;

    typedef struct packed {
        logic             has;
        logic [MSG_W-1:0] code;
    } stage_msg_t;

    function automatic stage_msg_t stage_msg(input logic [SEL_W-1:0] b);
        stage_msg_t m;
        m.has  = 1'b1;
        m.code = '0;
        case (b)
            4'd1:    m.code = 8'h01;
            4'd2:    m.code = 8'h02;
            4'd3:    m.code = 8'h03;
            4'd4:    m.code = 8'h04;
            4'd6:    m.code = 8'h06;
            4'd7:    m.code = 8'h0A;
            4'd9:    m.code = 8'h09;
            4'd10:   m.code = 8'h0E;
            4'd12:   m.code = 8'h0D;
            4'd14:   m.code = 8'h14;
            default: m.has  = 1'b0;
        endcase
        return m;
    endfunction

    function automatic logic word_ok(input logic [CW_BITS-1:0] w);
        return w[0] && ((w & RSVD_MASK) == '0);
    endfunction

endpackage

// File: rtl/train_seq_picker.sv
module train_seq_picker #(
    parameter int N  = 16,
    parameter int IW = 4
) (
    input  logic [N-1:0]  en,
    input  logic [IW-1:0] from,
    output logic          found,
    output logic [IW-1:0] pick
);
    logic [N-1:0] cand;

    for (genvar i = 0; i < N; i++) begin : g_cand
        localparam logic [IW-1:0] IDX = IW'(i);
        assign cand[i] = en[i] && (IDX >= from);
    end

    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i]) begin
                found = 1'b1;
                pick  = IW'(i);
            end
        end
    end
endmodule

// File: rtl/train_seq_mailbox.sv
module train_seq_mailbox #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] push_code,
    input  logic         ack,
    output logic         valid,
    output logic [W-1:0] code
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            code  <= '0;
        end else if (push && !valid) begin
            valid <= 1'b1;
            code  <= push_code;
        end else if (valid && ack) begin
            valid <= 1'b0;
        end
    end

    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (valid && !ack) |=> (valid && $stable(code)));
    a_r9_clear: assert property (@(posedge clk) disable iff (rst)
        (valid && ack) |=> !valid);
    a_r9_no_overwrite: assert property (@(posedge clk) disable iff (rst)
        push |-> !valid);
endmodule

// File: rtl/train_seq_fsm.sv
module train_seq_fsm
    import train_seq_pkg::*;
#(
    parameter int CW = CW_BITS,
    parameter int SW = SEL_W,
    parameter int MW = MSG_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [CW-1:0] ctrl_word,
    input  logic          stg_done,
    input  logic          stg_fail,
    input  logic          mbx_busy,
    input  logic          pk_found,
    input  logic [SW-1:0] pk_idx,
    output logic [CW-1:0] cword,
    output logic [SW-1:0] scan_from,
    output logic          stg_start,
    output logic [SW-1:0] stg_sel,
    output logic          push,
    output logic [MW-1:0] push_code,
    output phase_t        phase,
    output logic          busy,
    output logic          failed,
    output logic          selfref
);
    seq_state_t    state, ret_state;
    logic [SW-1:0] cur;
    logic [MW-1:0] pend;
    stage_msg_t    cur_msg;

    assign cur_msg   = stage_msg(cur);
    assign stg_start = (state == S_LAUNCH);
    assign stg_sel   = cur;
    assign push      = (state == S_POST) && !mbx_busy;
    assign push_code = pend;
    assign busy      = !(state inside {S_IDLE, S_MISSION, S_HALT});
    assign failed    = (state == S_HALT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            ret_state <= S_IDLE;
            phase     <= PH_POWER;
            cword     <= '0;
            scan_from <= '0;
            cur       <= '0;
            pend      <= '0;
            selfref   <= 1'b0;
        end else begin
            case (state)
                S_IDLE, S_MISSION, S_HALT: begin
                    if (start) begin
                        cword   <= ctrl_word;
                        phase   <= PH_POWER;
                        selfref <= 1'b0;
                        state   <= S_BRING;
                    end
                end
                S_BRING: begin
                    if (phase == PH_PARAM) begin
                        phase <= PH_EXEC;
                        state <= S_CHECK;
                    end else begin
                        phase <= phase_t'(phase + 4'd1);
                    end
                end
                S_CHECK: begin
                    if (word_ok(cword)) begin
                        pend      <= MSG_STREAM;
                        ret_state <= S_SEEK;
                        scan_from <= '0;
                    end else begin
                        pend      <= MSG_FAIL;
                        ret_state <= S_HALT;
                    end
                    state <= S_POST;
                end
                S_SEEK: begin
                    if (pk_found) begin
                        cur   <= pk_idx;
                        state <= S_LAUNCH;
                    end else begin
                        pend      <= MSG_PASS;
                        ret_state <= S_TAIL;
                        state     <= S_POST;
                    end
                end
                S_LAUNCH: state <= S_WAIT;
                S_WAIT: begin
                    if (stg_done) begin
                        if (stg_fail) begin
                            pend      <= MSG_FAIL;
                            ret_state <= S_HALT;
                            state     <= S_POST;
                        end else begin
                            scan_from <= cur + 1'b1;
                            if (cur_msg.has) begin
                                pend      <= cur_msg.code;
                                ret_state <= S_SEEK;
                                state     <= S_POST;
                            end else begin
                                state <= S_SEEK;
                            end
                        end
                    end
                end
                S_POST: begin
                    if (!mbx_busy) begin
                        state <= ret_state;
                        if (ret_state == S_TAIL) begin
                            phase   <= PH_RESULTS;
                            selfref <= 1'b1;
                        end
                    end
                end
                S_TAIL: begin
                    if (phase == PH_DFI) begin
                        phase <= PH_MISSION;
                        state <= S_MISSION;
                    end else begin
                        phase <= phase_t'(phase + 4'd1);
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
        stg_start |=> !stg_start);
    a_r5_enabled_only: assert property (@(posedge clk) disable iff (rst)
        stg_start |-> cword[stg_sel]);
    a_r3_valid_word: assert property (@(posedge clk) disable iff (rst)
        stg_start |-> (cword[0] && ((cword & RSVD_MASK) == '0)));
    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        (state == S_BRING && phase != PH_PARAM) |=> (phase == phase_t'($past(phase) + 4'd1)));
    a_r7_selfref_late: assert property (@(posedge clk) disable iff (rst)
        selfref |-> (phase >= PH_RESULTS));
    a_r8_halt_no_stage: assert property (@(posedge clk) disable iff (rst)
        failed |-> !stg_start);
endmodule

// File: rtl/train_seq_top.sv
module train_seq_top
    import train_seq_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [15:0]  ctrl_word,
    output logic         stg_start,
    output logic [3:0]   stg_sel,
    input  logic         stg_done,
    input  logic         stg_fail,
    output logic         mbx_valid,
    output logic [7:0]   mbx_code,
    input  logic         mbx_ack,
    output logic [3:0]   phase,
    output logic         busy,
    output logic         failed,
    output logic         selfref
);
    logic [CW_BITS-1:0] cword;
    logic [SEL_W-1:0]   scan_from, pk_idx;
    logic               pk_found, push;
    logic [MSG_W-1:0]   push_code;
    phase_t             ph;

    assign phase = ph;

    train_seq_picker #(.N(CW_BITS), .IW(SEL_W)) u_pick (
        .en(cword), .from(scan_from), .found(pk_found), .pick(pk_idx)
    );

    train_seq_fsm u_fsm (
        .clk(clk), .rst(rst), .start(start), .ctrl_word(ctrl_word),
        .stg_done(stg_done), .stg_fail(stg_fail), .mbx_busy(mbx_valid),
        .pk_found(pk_found), .pk_idx(pk_idx), .cword(cword),
        .scan_from(scan_from), .stg_start(stg_start), .stg_sel(stg_sel),
        .push(push), .push_code(push_code), .phase(ph), .busy(busy),
        .failed(failed), .selfref(selfref)
    );

    train_seq_mailbox #(.W(MSG_W)) u_mbx (
        .clk(clk), .rst(rst), .push(push), .push_code(push_code),
        .ack(mbx_ack), .valid(mbx_valid), .code(mbx_code)
    );
endmodule

// File: tb/train_seq_top_test.sv
module train_seq_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] ctrl_word = '0;
    logic        stg_start, stg_done = 1'b0, stg_fail = 1'b0;
    logic [3:0]  stg_sel, phase;
    logic        mbx_valid, mbx_ack = 1'b0, busy, failed, selfref;
    logic [7:0]  mbx_code;
    int          n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    train_seq_top uut (
        .clk(clk), .rst(rst), .start(start), .ctrl_word(ctrl_word),
        .stg_start(stg_start), .stg_sel(stg_sel), .stg_done(stg_done),
        .stg_fail(stg_fail), .mbx_valid(mbx_valid), .mbx_code(mbx_code),
        .mbx_ack(mbx_ack), .phase(phase), .busy(busy), .failed(failed),
        .selfref(selfref)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_code(input int b);
        case (b)
            1: return 8'h01;  2: return 8'h02;  3: return 8'h03;
            4: return 8'h04;  6: return 8'h06;  7: return 8'h0A;
            9: return 8'h09;  10: return 8'h0E; 12: return 8'h0D;
            14: return 8'h14;
            default: return 8'h00;
        endcase
    endfunction

    task automatic run_case(input logic [15:0] w, input int fail_at, input int lat);
        logic [7:0] ecodes[$];
        int eids[$];
        bit ok, halted, ackd, stpl;
        int ci, ii, cnt, hw, cyc, cur, pph, perr;
        string tag;
        ok = w[0] && ((w & 16'h8920) == 16'h0);
        halted = !ok;
        if (!ok) ecodes.push_back(8'hFF);
        else begin
            ecodes.push_back(8'h08);
            for (int b = 0; b < 15; b++) begin
                if (w[b] && !halted) begin
                    eids.push_back(b);
                    if (b == fail_at) begin
                        ecodes.push_back(8'hFF);
                        halted = 1'b1;
                    end else if (exp_code(b) != 8'h00) begin
                        ecodes.push_back(exp_code(b));
                    end
                end
            end
            if (!halted) ecodes.push_back(8'h07);
        end
        ctrl_word = w;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(phase == 4'd0 && !selfref && !failed && busy, "R10 restart state",
            {phase, selfref, failed, busy}, 4'b0001);
        ci = 0; ii = 0; cnt = 0; hw = lat; ackd = 0; stpl = 0; cyc = 0;
        cur = -1; pph = 0; perr = 0;
        while (cyc < 3000) begin
            @(negedge clk);
            cyc++;
            stg_done = 1'b0;
            stg_fail = 1'b0;
            if (ackd) begin
                ackd = 1'b0;
                mbx_ack = 1'b0;
                chk(!mbx_valid, "R9 valid clears after ack", mbx_valid, 0);
                hw = lat;
            end else if (mbx_valid) begin
                if (hw == 0) begin
                    if (!ok) tag = "R3 reject message";
                    else if (ci == 0) tag = "R4 stream entry message";
                    else if (ci < ecodes.size() && ecodes[ci] == 8'hFF) tag = "R8 fail message";
                    else if (ci == ecodes.size() - 1) tag = "R7 pass message";
                    else tag = "R6 stage message";
                    if (ci < ecodes.size())
                        chk(mbx_code == ecodes[ci], tag, mbx_code, ecodes[ci]);
                    else
                        chk(1'b0, "R6 extra message", mbx_code, 0);
                    ci++;
                    mbx_ack = 1'b1;
                    ackd = 1'b1;
                end else hw--;
            end
            if (stpl) begin
                chk(!stg_start, "R5 start is one cycle", stg_start, 0);
                stpl = 1'b0;
            end
            if (cnt > 0) begin
                cnt--;
                if (cnt == 0) begin
                    stg_done = 1'b1;
                    stg_fail = (cur == fail_at);
                end
            end
            if (stg_start) begin
                if (ii < eids.size())
                    chk(int'(stg_sel) == eids[ii], "R5 stage order", stg_sel, eids[ii]);
                else
                    chk(1'b0, "R5 unexpected stage", stg_sel, 0);
                ii++;
                cur = int'(stg_sel);
                cnt = lat + 1;
                stpl = 1'b1;
            end
            if (int'(phase) != pph && int'(phase) != pph + 1) perr++;
            pph = int'(phase);
            if (!busy && !mbx_valid && !ackd) break;
        end
        chk(cyc < 3000, "R5 run completes", cyc, 3000);
        chk(ci == ecodes.size(), "R6 message count", ci, ecodes.size());
        chk(ii == eids.size(), "R5 stage count", ii, eids.size());
        chk(perr == 0, "R2 phase steps by one", perr, 0);
        if (ok && !halted) begin
            chk(phase == 4'd10, "R7 mission phase", phase, 10);
            chk(selfref && !failed, "R7 self-refresh flag", {selfref, failed}, 2'b10);
        end else begin
            chk(phase == 4'd6, halted && ok ? "R8 phase held" : "R3 phase held", phase, 6);
            chk(failed && !selfref, ok ? "R8 failed flag" : "R3 failed flag",
                {failed, selfref}, 2'b10);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !failed && !selfref && !stg_start && !mbx_valid && phase == 4'd0,
            "R1 reset state", {busy, failed, selfref, stg_start, mbx_valid, phase}, 0);
        run_case(16'h0000, -1, 0);
        run_case(16'h0002, -1, 1);
        run_case(16'h76DE, -1, 2);
        for (int k = 0; k < 16; k++)
            run_case(16'h0001 | (16'h1 << k), -1, k % 4);
        run_case(16'h76DF, -1, 0);
        run_case(16'h76DF, -1, 3);
        run_case(16'hFFFF, -1, 1);
        run_case(16'h2001, -1, 2);
        for (int k = 0; k < 15; k++)
            if (16'h76DF & (16'h1 << k)) run_case(16'h76DF, k, (k + 1) % 4);
        run_case(16'h5241, 9, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule